// File: doc/BRIEF.md
# Load/Store Alignment and Fault Unit

This unit sits between the execute stage of a 32-bit RISC-V core and its data bus. For each memory instruction it forms the effective address, works out how many bytes are moved, and checks that the address is a multiple of that size. An aligned access goes out on the bus. A misaligned one is turned into a trap and never reaches the bus. The unit handles the 32-bit load and store forms and the compressed word forms, including the stack-relative variants that take x2 as their base.

When a load completes, the returned data is sign- or zero-extended according to funct3 and handed back for writeback. A bus error on a load becomes an access-fault trap, and rd is not written. Every trap carries its cause code and the computed address, which the trap unit records as the bad-address value. A successful completion also reports how far the PC advances.

The unit handles one access at a time. `req_ready` is low from acceptance until the completion or trap pulse has been shown. The caller decodes register fields. For the stack-relative compressed store, the caller supplies the value of the register named by instruction bits 6:2 on `req_wdata`.

Top module: `mem_align_unit`

## Requirements
- R1: The effective address is the base plus the immediate, modulo 2^32. The base is `req_base`, except for a compressed stack-relative access (`req_cmp`=1 and `req_sp`=1), which uses `req_sp_val` (x2).
- R2: The access size is 1 << funct3[1:0] bytes for 32-bit forms and always 4 bytes for compressed forms. `bus_req_size` carries log2 of the size: 0 = byte, 1 = halfword, 2 = word.
- R3: A load whose address has any bit below its size set produces a trap with cause 4 and `trap_addr` equal to the address. No bus request is made.
- R4: A misaligned store produces a trap with cause 6 and `trap_addr` equal to the address. No bus write is issued.
- R5: A load whose bus response has `bus_rsp_err`=1 produces a trap with cause 5 and `trap_addr` equal to the address. `wb_valid` and `done_valid` stay low for that load.
- R6: Load data is returned right-justified in `bus_rsp_rdata` and extended as follows. funct3 0 sign-extends a byte. funct3 1 sign-extends a halfword. funct3 2 passes the word. funct3 4 zero-extends a byte. funct3 5 zero-extends a halfword. A compressed load behaves as funct3 2.
- R7: On successful completion, `done_valid` pulses for one cycle with `done_pc_step` equal to 2 for compressed forms and 4 otherwise. `wb_valid` pulses with it for loads only.
- R8: `trap_valid` is a single-cycle pulse, one cycle after acceptance for misalignment, or one cycle after the response for a bus error. While `req_ready` is low, `req_valid` is ignored and starts no access or trap.
- R9: An aligned access holds `bus_req_valid`, address, size, write flag and `req_wdata` stable until the cycle in which `bus_rsp_valid` is high. A store sets `bus_req_we`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Memory instruction presented |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_cmp | input | 1 | Compressed word form |
| req_sp | input | 1 | Stack-relative compressed form (base x2) |
| req_funct3 | input | 3 | funct3 of 32-bit forms |
| req_base | input | 32 | Base register value |
| req_sp_val | input | 32 | Value of x2 |
| req_imm | input | 32 | Sign-extended immediate / offset |
| req_wdata | input | 32 | Store data |
| bus_req_valid | output | 1 | Bus access request |
| bus_req_we | output | 1 | Bus write |
| bus_req_addr | output | 32 | Bus address |
| bus_req_size | output | 2 | log2 of bytes |
| bus_req_wdata | output | 32 | Bus write data |
| bus_rsp_valid | input | 1 | Bus response, completes the request |
| bus_rsp_err | input | 1 | Bus response error |
| bus_rsp_rdata | input | 32 | Right-justified read data |
| done_valid | output | 1 | Successful completion pulse |
| done_pc_step | output | 3 | PC advance, 2 or 4 |
| wb_valid | output | 1 | Write rd with wb_data |
| wb_data | output | 32 | Extended load data |
| trap_valid | output | 1 | Exception pulse |
| trap_cause | output | 4 | Exception code 4, 5 or 6 |
| trap_addr | output | 32 | Faulting address |

## Verification
The hardest case to reach is a request that arrives while an access is still outstanding. It has to stay invisible, and it has to stay invisible even when it is misaligned and would trap if accepted. The bench holds back the bus response for several cycles and drives a misaligned load during that window. It then checks that exactly one completion appears and that no trap follows. The bus-error path is reached by sweeping the bench's bus model over every aligned load form and offset with the error flag both clear and set.

// File: rtl/mem_align_pkg.sv
package mem_align_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUS  = 1'b1
   } lsu_state_e;

   localparam int unsigned CAUSE_W = 4;
   localparam logic [CAUSE_W-1:0] CAUSE_LD_MISALIGN = 4'd4;
   localparam logic [CAUSE_W-1:0] CAUSE_LD_FAULT    = 4'd5;
   localparam logic [CAUSE_W-1:0] CAUSE_ST_MISALIGN = 4'd6;
   localparam logic [2:0]         F3_WORD           = 3'b010;
endpackage

// File: rtl/mem_addr_gen.sv
module mem_addr_gen #(
   parameter int unsigned XLEN       = 32,
   parameter bit          SP_FORM_EN = 1'b1
) (
   input  logic [XLEN-1:0]            base_i,
   input  logic [XLEN-1:0]            sp_i,
   input  logic [XLEN-1:0]            imm_i,
   input  logic                       use_sp_i,
   input  logic                       cmp_i,
   input  logic [2:0]                 funct3_i,
   output logic [XLEN-1:0]            addr_o,
   output mem_align_pkg::acc_size_e   size_o,
   output logic [2:0]                 funct3_eff_o
);
   import mem_align_pkg::*;

   logic [XLEN-1:0] base_sel;

   generate
      if (SP_FORM_EN) begin : g_sp
         assign base_sel = (cmp_i && use_sp_i) ? sp_i : base_i;
      end else begin : g_nosp
         logic unused_sp;
         assign unused_sp = ^{sp_i, use_sp_i};
         assign base_sel  = base_i;
      end
   endgenerate

   assign addr_o       = base_sel + imm_i;
   assign funct3_eff_o = cmp_i ? F3_WORD : funct3_i;

   always_comb begin
      unique case (funct3_eff_o[1:0])
         2'd0:    size_o = SZ_BYTE;
         2'd1:    size_o = SZ_HALF;
         default: size_o = SZ_WORD;
      endcase
   end
endmodule

// File: rtl/mem_align_check.sv
module mem_align_check #(
   parameter int unsigned LOW_BITS = 2
) (
   input  logic [LOW_BITS-1:0]      addr_lo_i,
   input  mem_align_pkg::acc_size_e size_i,
   output logic                     misaligned_o
);
   logic [LOW_BITS-1:0] mask;

   generate
      for (genvar b = 0; b < LOW_BITS; b++) begin : g_mask
         assign mask[b] = (int'(size_i) > b);
      end
   endgenerate

   assign misaligned_o = |(addr_lo_i & mask);
endmodule

// File: rtl/mem_load_extend.sv
module mem_load_extend #(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0] rdata_i,
   input  logic [2:0]      funct3_i,
   output logic [XLEN-1:0] data_o
);
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned HALF_W = 16;

   logic sign_b, sign_h;
   assign sign_b = rdata_i[BYTE_W-1] & ~funct3_i[2];
   assign sign_h = rdata_i[HALF_W-1] & ~funct3_i[2];

   always_comb begin
      unique case (funct3_i[1:0])
         2'd0:    data_o = {{(XLEN-BYTE_W){sign_b}}, rdata_i[BYTE_W-1:0]};
         2'd1:    data_o = {{(XLEN-HALF_W){sign_h}}, rdata_i[HALF_W-1:0]};
         default: data_o = rdata_i;
      endcase
   end
endmodule

// File: rtl/mem_align_unit.sv
module mem_align_unit #(
   parameter int unsigned XLEN       = 32,
   parameter bit          SP_FORM_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic            req_store,
   input  logic            req_cmp,
   input  logic            req_sp,
   input  logic [2:0]      req_funct3,
   input  logic [XLEN-1:0] req_base,
   input  logic [XLEN-1:0] req_sp_val,
   input  logic [XLEN-1:0] req_imm,
   input  logic [XLEN-1:0] req_wdata,
   output logic            bus_req_valid,
   output logic            bus_req_we,
   output logic [XLEN-1:0] bus_req_addr,
   output logic [1:0]      bus_req_size,
   output logic [XLEN-1:0] bus_req_wdata,
   input  logic            bus_rsp_valid,
   input  logic            bus_rsp_err,
   input  logic [XLEN-1:0] bus_rsp_rdata,
   output logic            done_valid,
   output logic [2:0]      done_pc_step,
   output logic            wb_valid,
   output logic [XLEN-1:0] wb_data,
   output logic            trap_valid,
   output logic [3:0]      trap_cause,
   output logic [XLEN-1:0] trap_addr
);
   import mem_align_pkg::*;

   localparam int unsigned LOW_BITS = 2;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("mem_align_unit: XLEN must be 32");
      end
   endgenerate

   lsu_state_e      state;
   logic [XLEN-1:0] addr_c;
   acc_size_e       size_c;
   logic [2:0]      f3_c;
   logic            mis_c;
   logic [2:0]      f3_q;
   logic            cmp_q;
   logic [XLEN-1:0] ext_c;
   logic            accept;

   mem_addr_gen #(.XLEN(XLEN), .SP_FORM_EN(SP_FORM_EN)) u_addr (
      .base_i(req_base), .sp_i(req_sp_val), .imm_i(req_imm),
      .use_sp_i(req_sp), .cmp_i(req_cmp), .funct3_i(req_funct3),
      .addr_o(addr_c), .size_o(size_c), .funct3_eff_o(f3_c)
   );

   mem_align_check #(.LOW_BITS(LOW_BITS)) u_chk (
      .addr_lo_i(addr_c[LOW_BITS-1:0]), .size_i(size_c), .misaligned_o(mis_c)
   );

   mem_load_extend #(.XLEN(XLEN)) u_ext (
      .rdata_i(bus_rsp_rdata), .funct3_i(f3_q), .data_o(ext_c)
   );

   assign req_ready = (state == ST_IDLE) && !trap_valid && !done_valid;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         bus_req_valid <= 1'b0;
         bus_req_we    <= 1'b0;
         bus_req_addr  <= '0;
         bus_req_size  <= '0;
         bus_req_wdata <= '0;
         f3_q          <= '0;
         cmp_q         <= 1'b0;
         done_valid    <= 1'b0;
         done_pc_step  <= '0;
         wb_valid      <= 1'b0;
         wb_data       <= '0;
         trap_valid    <= 1'b0;
         trap_cause    <= '0;
         trap_addr     <= '0;
      end else begin
         done_valid <= 1'b0;
         wb_valid   <= 1'b0;
         trap_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  f3_q  <= f3_c;
                  cmp_q <= req_cmp;
                  if (mis_c) begin
                     trap_valid <= 1'b1;
                     trap_cause <= req_store ? CAUSE_ST_MISALIGN : CAUSE_LD_MISALIGN;
                     trap_addr  <= addr_c;
                  end else begin
                     state         <= ST_BUS;
                     bus_req_valid <= 1'b1;
                     bus_req_we    <= req_store;
                     bus_req_addr  <= addr_c;
                     bus_req_size  <= size_c;
                     bus_req_wdata <= req_wdata;
                  end
               end
            end
            ST_BUS: begin
               if (bus_rsp_valid) begin
                  state         <= ST_IDLE;
                  bus_req_valid <= 1'b0;
                  if (!bus_req_we && bus_rsp_err) begin
                     trap_valid <= 1'b1;
                     trap_cause <= CAUSE_LD_FAULT;
                     trap_addr  <= bus_req_addr;
                  end else begin
                     done_valid   <= 1'b1;
                     done_pc_step <= cmp_q ? 3'd2 : 3'd4;
                     wb_valid     <= !bus_req_we;
                     wb_data      <= ext_c;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R8: trap strobe lasts one cycle
   p_trap_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |=> !trap_valid);

   // R3: nothing misaligned ever reaches the bus
   p_bus_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid |-> ((bus_req_addr[1:0] & ((2'd1 << bus_req_size) - 2'd1)) == 2'd0));

   // R3: cause codes are limited to the three defined values
   p_cause_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> (trap_cause inside {4'd4, 4'd5, 4'd6}));

   // R5: a trap never coincides with writeback or completion
   p_trap_no_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> (!wb_valid && !done_valid));

   // R9: request held until the response
   p_bus_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && !bus_rsp_valid) |=> (bus_req_valid && $stable(bus_req_addr)
                                             && $stable(bus_req_we)));

   // R7: PC advance is 2 or 4, writeback only on completion
   p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (done_pc_step == 3'd2 || done_pc_step == 3'd4));
   p_wb_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> done_valid);
endmodule

// File: tb/mem_align_unit_bench.sv
module mem_align_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_store = 1'b0, req_cmp = 1'b0, req_sp = 1'b0;
   logic [2:0]  req_funct3 = '0;
   logic [31:0] req_base = '0, req_sp_val = '0, req_imm = '0, req_wdata = '0;
   logic        bus_rsp_valid = 1'b0, bus_rsp_err = 1'b0;
   logic [31:0] bus_rsp_rdata = '0;
   logic        req_ready, bus_req_valid, bus_req_we, done_valid, wb_valid, trap_valid;
   logic [31:0] bus_req_addr, bus_req_wdata, wb_data, trap_addr;
   logic [1:0]  bus_req_size;
   logic [2:0]  done_pc_step;
   logic [3:0]  trap_cause;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   mem_align_unit u_mem_align_unit (
      .clk, .rst_n, .req_valid, .req_ready, .req_store, .req_cmp, .req_sp,
      .req_funct3, .req_base, .req_sp_val, .req_imm, .req_wdata,
      .bus_req_valid, .bus_req_we, .bus_req_addr, .bus_req_size, .bus_req_wdata,
      .bus_rsp_valid, .bus_rsp_err, .bus_rsp_rdata,
      .done_valid, .done_pc_step, .wb_valid, .wb_data,
      .trap_valid, .trap_cause, .trap_addr
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ext(input logic [31:0] d, input logic [2:0] f3);
      case (f3)
         3'd0: return 32'($signed(d[7:0]));
         3'd1: return 32'($signed(d[15:0]));
         3'd4: return {24'd0, d[7:0]};
         3'd5: return {16'd0, d[15:0]};
         default: return d;
      endcase
   endfunction

   task automatic run_one(input bit st, input bit cmp, input bit sp, input logic [2:0] f3,
                          input logic [31:0] base, input logic [31:0] spv,
                          input logic [31:0] imm, input logic [31:0] wd,
                          input bit err, input logic [31:0] rd);
      logic [31:0] ea;
      int          lg;
      bit          mis, saw_bus, got_trap, got_done;
      ea  = ((cmp && sp) ? spv : base) + imm;            // R1
      lg  = cmp ? 2 : int'(f3[1:0]);                      // R2
      mis = (ea & ((32'd1 << lg) - 1)) != 0;
      saw_bus = 0; got_trap = 0; got_done = 0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_store = st; req_cmp = cmp; req_sp = sp; req_funct3 = f3;
      req_base = base; req_sp_val = spv; req_imm = imm; req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      for (int k = 0; k < 6; k++) begin
         if (bus_req_valid && !bus_rsp_valid) begin
            saw_bus = 1;
            chk(bus_req_addr == ea, "R1 address", bus_req_addr, ea);
            chk(bus_req_size == 2'(lg), "R2 size", 32'(bus_req_size), 32'(lg));
            chk(bus_req_we == st, "R9 write flag", 32'(bus_req_we), 32'(st));
            if (st) chk(bus_req_wdata == wd, "R9 wdata", bus_req_wdata, wd);
            bus_rsp_valid = 1; bus_rsp_err = err; bus_rsp_rdata = rd;
         end else begin
            bus_rsp_valid = 0; bus_rsp_err = 0;
         end
         if (trap_valid || done_valid) begin
            got_trap = trap_valid; got_done = done_valid;
            break;
         end
         @(negedge clk);
      end
      bus_rsp_valid = 0; bus_rsp_err = 0;
      if (mis) begin
         chk(got_trap && !saw_bus, st ? "R4 misaligned store trap, no bus" :
             "R3 misaligned load trap, no bus", 32'(saw_bus), 32'd0);
         chk(trap_cause == (st ? 4'd6 : 4'd4), st ? "R4 cause" : "R3 cause",
             32'(trap_cause), st ? 32'd6 : 32'd4);
         chk(trap_addr == ea, st ? "R4 address" : "R3 address", trap_addr, ea);
      end else if (!st && err) begin
         chk(got_trap && !got_done && !wb_valid, "R5 fault trap no wb", 32'(wb_valid), 32'd0);
         chk(trap_cause == 4'd5, "R5 cause", 32'(trap_cause), 32'd5);
         chk(trap_addr == ea, "R5 address", trap_addr, ea);
      end else begin
         chk(got_done, "R7 completion", 32'(got_done), 32'd1);
         chk(done_pc_step == (cmp ? 3'd2 : 3'd4), "R7 pc step", 32'(done_pc_step),
             cmp ? 32'd2 : 32'd4);
         chk(wb_valid == !st, "R7 wb only for loads", 32'(wb_valid), 32'(!st));
         if (!st) chk(wb_data == ext(rd, cmp ? 3'd2 : f3), "R6 extension", wb_data,
                      ext(rd, cmp ? 3'd2 : f3));
      end
      if (got_trap) begin
         @(negedge clk);
         chk(!trap_valid, "R8 trap single pulse", 32'(trap_valid), 32'd0);
      end
   endtask

   initial begin
      logic [2:0] f3s [5] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5};
      repeat (3) @(negedge clk);
      chk(!bus_req_valid && !trap_valid && !done_valid && !wb_valid, "R8 reset idle",
          {bus_req_valid, trap_valid, done_valid, wb_valid}, 32'd0);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready, "R8 ready after reset", 32'(req_ready), 32'd1);
      // 32-bit loads: every funct3, offset, error flag, two data patterns
      for (int fi = 0; fi < 5; fi++)
         for (int off = 0; off < 4; off++)
            for (int e = 0; e < 2; e++)
               for (int p = 0; p < 2; p++)
                  run_one(0, 0, 0, f3s[fi], 32'h1000 + 32'(off), 32'h7777,
                          p ? 32'hFFFF_FFFC : 32'd8, 32'h0, e[0],
                          p ? 32'h8000_80F3 : 32'h1234_5678);
      // 32-bit stores
      for (int f = 0; f < 3; f++)
         for (int off = 0; off < 4; off++)
            run_one(1, 0, 0, 3'(f), 32'h2000, 32'h7777, 32'(off) + 32'd4,
                    32'hCAFE_0000 + 32'(off), 0, 32'h0);
      // compressed forms: plain and stack-relative, loads and stores
      for (int sp = 0; sp < 2; sp++)
         for (int st = 0; st < 2; st++)
            for (int off = 0; off < 4; off++)
               for (int e = 0; e < 2; e++)
                  run_one(st[0], 1, sp[0], 3'd0, 32'h3000, 32'h4000 + 32'(off),
                          sp ? 32'd12 : 32'(off) + 32'd16, 32'hBEEF_0001,
                          e[0] & !st[0], 32'h8001_FF80);
      // R8: request while busy is ignored
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_store = 0; req_cmp = 0; req_sp = 0; req_funct3 = 3'd2;
      req_base = 32'h5000; req_imm = 32'd0;
      @(posedge clk);
      @(negedge clk);
      req_base = 32'h5001;   // misaligned, presented while busy
      chk(!req_ready && bus_req_valid, "R8 busy after accept", 32'(req_ready), 32'd0);
      repeat (3) @(negedge clk);
      chk(bus_req_addr == 32'h5000, "R9 address held while waiting", bus_req_addr,
          32'h5000);
      req_valid = 0;
      bus_rsp_valid = 1; bus_rsp_rdata = 32'h0000_0042;
      @(negedge clk);
      bus_rsp_valid = 0;
      chk(done_valid && wb_data == 32'h42, "R8 single completion", wb_data, 32'h42);
      begin
         bit seen = 0;
         for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (trap_valid || bus_req_valid) seen = 1;
         end
         chk(!seen, "R8 busy request ignored", 32'(seen), 32'd0);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++; checks++;
         $display("FAIL watchdog actual=%0d expected<=100000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule